// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

The unit fills one vector register from a word-addressed memory that is split into independently addressed banks. A single start request supplies a base word address, a stride and an element count. The unit then walks the addresses base, base+stride, base+2·stride and so on. It sends at most one request per cycle to the bank that owns each address. When the next element's bank has not finished its previous access, the unit waits. Replies come back after a fixed pipelined latency and are written into the destination register at their element positions. A one-cycle done pulse marks the end of the load.

The memory banks are modelled behaviourally. Each bank has a fixed busy window after it accepts a request. Every read returns a word computed from its address, so no storage array is needed. Unit-stride loads move one element per cycle once the pipeline is full. A stride whose every address falls in one bank is limited by that bank's busy window.

Top module: `vlu_strided_load`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every destination element reads as 0.
- R2: Element i is fetched from word address (base_i + i·stride_i) mod 2^16. The word returned for address A has A in bits 15:0 and A XOR 0x5A3C in bits 31:16. It is stored at destination index i.
- R3: The bank of address A is A mod 8. A bank that accepts a request cannot accept another for 6 cycles. Requests go out in element order, at most one per cycle, and issue stalls while the next element's bank is busy.
- R4: Data is written 12 cycles after its request issues. The first request issues on the edge after the start edge. done_o is high for exactly one cycle, beginning at the edge of the last write. A 64-element unit-stride load therefore raises done_o 76 edges after the start edge.
- R5: A 64-element load with stride 32 sends every element to one bank and raises done_o 391 edges after the start edge.
- R6: A requested length above 64 is treated as 64.
- R7: With a length of 0, nothing is written, busy_o stays 0 and done_o is high right after the start edge.
- R8: Destination elements at indices at or above the current length keep their previous contents.
- R9: start_i is ignored while busy_o is 1.
- R10: busy_o rises at the edge that accepts a non-empty load and falls at the edge where done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (sampled when idle) |
| base_i | input | 16 | Word address of element 0 |
| stride_i | input | 16 | Address step between elements (wraps modulo 2^16) |
| vl_i | input | 7 | Requested element count |
| rd_idx_i | input | 6 | Destination element to read |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| rd_data_o | output | 32 | Destination element selected by rd_idx_i |

## Verification
The bench builds the unit with its defaults: 8 banks, a 6-cycle busy window, a 12-cycle latency and 64 elements. With these values the two headline load times, 76 and 391 cycles, can be checked exactly. The bench computes the expected completion time of every load from a per-bank free-time model. Its loads cover strides that visit all banks, strides that revisit banks every two or four elements, a zero stride, a negative stride and an address wrap, so each kind of stall pattern is compared cycle for cycle. Length clamping, a zero length, partial overwrites and a start attempted mid-load are checked through the read port.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned BANKS_DEF  = 8;
  localparam int unsigned BUSY_DEF   = 6;
  localparam int unsigned LAT_DEF    = 12;
  localparam int unsigned MVL_DEF    = 64;
  // upper half of a returned word is the address xored with this
  localparam logic [15:0] DATA_SALT  = 16'h5A3C;
endpackage

// File: rtl/vlu_addr_issue.sv
module vlu_addr_issue #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NB   = 8,
  parameter int unsigned BUSY = 6,
  parameter int unsigned VLW  = 7,
  parameter int unsigned IW   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [VLW-1:0] vl_i,
  output logic          req_vld_o,
  output logic [AW-1:0] req_addr_o,
  output logic [IW-1:0] req_idx_o
);
  localparam int unsigned BW = $clog2(NB);
  localparam int unsigned CW = $clog2(BUSY + 1);

  logic           act_q;
  logic [IW-1:0]  idx_q;
  logic [VLW-1:0] vl_q;
  logic [AW-1:0]  addr_q, stride_q;
  logic [BW-1:0]  bank;
  logic [NB-1:0]  bank_free;

  assign bank = addr_q[BW-1:0];

  // per-bank busy window counters
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (req_vld_o && bank == BW'(b))   cnt_q <= CW'(BUSY - 1);
      else if (cnt_q != '0)                   cnt_q <= cnt_q - 1'b1;
    end
    assign bank_free[b] = (cnt_q == '0);
  end

  assign req_vld_o  = act_q && bank_free[bank];
  assign req_addr_o = addr_q;
  assign req_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      idx_q    <= '0;
      vl_q     <= '0;
      addr_q   <= '0;
      stride_q <= '0;
    end else if (go_i) begin
      act_q    <= (vl_i != '0);
      idx_q    <= '0;
      vl_q     <= vl_i;
      addr_q   <= base_i;
      stride_q <= stride_i;
    end else if (req_vld_o) begin
      addr_q <= addr_q + stride_q;
      idx_q  <= idx_q + 1'b1;
      if (idx_q == IW'(vl_q - 1'b1)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vlu_bank_array.sv
module vlu_bank_array
  import vlu_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned NB  = 8,
  parameter int unsigned LAT = 12,
  parameter int unsigned IW  = 6,
  parameter int unsigned DW  = 2 * AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_vld_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [IW-1:0] req_idx_i,
  output logic          rsp_vld_o,
  output logic [IW-1:0] rsp_idx_o,
  output logic [DW-1:0] rsp_data_o
);
  localparam int unsigned BW = $clog2(NB);

  logic [BW-1:0]    bank_sel;
  logic [AW-BW-1:0] row_sel;
  logic [AW-1:0]    word_addr;
  logic [DW-1:0]    rd_word;

  assign bank_sel  = req_addr_i[BW-1:0];
  assign row_sel   = req_addr_i[AW-1:BW];
  assign word_addr = {row_sel, bank_sel};
  assign rd_word   = {word_addr ^ AW'(DATA_SALT), word_addr};

  logic          vld_q [LAT];
  logic [IW-1:0] idx_q [LAT];
  logic [DW-1:0] dat_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) begin
        vld_q[k] <= 1'b0;
        idx_q[k] <= '0;
        dat_q[k] <= '0;
      end
    end else begin
      vld_q[0] <= req_vld_i;
      idx_q[0] <= req_idx_i;
      dat_q[0] <= rd_word;
      for (int k = 1; k < LAT; k++) begin
        vld_q[k] <= vld_q[k-1];
        idx_q[k] <= idx_q[k-1];
        dat_q[k] <= dat_q[k-1];
      end
    end
  end

  assign rsp_vld_o  = vld_q[LAT-1];
  assign rsp_idx_o  = idx_q[LAT-1];
  assign rsp_data_o = dat_q[LAT-1];
endmodule

// File: rtl/vlu_elem_reg.sv
module vlu_elem_reg #(
  parameter int unsigned DW  = 32,
  parameter int unsigned MVL = 64,
  parameter int unsigned IW  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] elem_q [MVL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < MVL; e++) elem_q[e] <= '0;
    end else if (wr_en_i) begin
      elem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = elem_q[rd_idx_i];
endmodule

// File: rtl/vlu_strided_load.sv
module vlu_strided_load
  import vlu_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W_DEF,
  parameter int unsigned NB   = BANKS_DEF,
  parameter int unsigned BUSY = BUSY_DEF,
  parameter int unsigned LAT  = LAT_DEF,
  parameter int unsigned MVL  = MVL_DEF,
  localparam int unsigned VLW = $clog2(MVL + 1),
  localparam int unsigned IW  = $clog2(MVL),
  localparam int unsigned DW  = 2 * AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  stride_i,
  input  logic [VLW-1:0] vl_i,
  input  logic [IW-1:0]  rd_idx_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  rd_data_o
);
  localparam int unsigned BW = $clog2(NB);

  logic           busy_q, done_q, go, last_wr;
  logic [VLW-1:0] vl_eff, vl_q;
  logic           req_vld, rsp_vld;
  logic [AW-1:0]  req_addr;
  logic [IW-1:0]  req_idx, rsp_idx;
  logic [DW-1:0]  rsp_data;

  assign vl_eff  = (vl_i > VLW'(MVL)) ? VLW'(MVL) : vl_i;
  assign go      = start_i && !busy_q;
  assign last_wr = rsp_vld && (rsp_idx == IW'(vl_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      vl_q   <= '0;
    end else begin
      done_q <= (go && vl_eff == '0) || last_wr;
      if (go) begin
        busy_q <= (vl_eff != '0);
        vl_q   <= vl_eff;
      end else if (last_wr) begin
        busy_q <= 1'b0;
      end
    end
  end

  vlu_addr_issue #(.AW(AW), .NB(NB), .BUSY(BUSY), .VLW(VLW), .IW(IW)) u_issue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .base_i    (base_i),
    .stride_i  (stride_i),
    .vl_i      (vl_eff),
    .req_vld_o (req_vld),
    .req_addr_o(req_addr),
    .req_idx_o (req_idx)
  );

  vlu_bank_array #(.AW(AW), .NB(NB), .LAT(LAT), .IW(IW), .DW(DW)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_vld_i (req_vld),
    .req_addr_i(req_addr),
    .req_idx_i (req_idx),
    .rsp_vld_o (rsp_vld),
    .rsp_idx_o (rsp_idx),
    .rsp_data_o(rsp_data)
  );

  vlu_elem_reg #(.DW(DW), .MVL(MVL), .IW(IW)) u_dest (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (rsp_vld),
    .wr_idx_i (rsp_idx),
    .wr_data_i(rsp_data),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/vlu_strided_load_chk.sv
module vlu_strided_load_chk #(
  parameter int unsigned BW = 3,
  parameter int unsigned IW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          req_vld_i,
  input logic [BW-1:0] req_bank_i,
  input logic          rsp_vld_i,
  input logic [IW-1:0] rsp_idx_i
);
  // R3
  bank_back2back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && $past(req_vld_i) |-> req_bank_i != $past(req_bank_i));

  // R2
  elem_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_i && $past(rsp_vld_i) |-> rsp_idx_i == IW'($past(rsp_idx_i) + 1'b1));

  // R4
  wr_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_i |-> busy_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind vlu_strided_load vlu_strided_load_chk #(.BW(BW), .IW(IW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .req_vld_i (req_vld),
  .req_bank_i(req_addr[BW-1:0]),
  .rsp_vld_i (rsp_vld),
  .rsp_idx_i (rsp_idx)
);

// File: tb/vlu_strided_load_tb_top.sv
module vlu_strided_load_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MVL = 64;
  localparam int NLOADS = 9;

  // {base, stride, length}
  localparam logic [39:0] LOADS [NLOADS] = '{
    {16'h0000, 16'd1,     8'd64},
    {16'h0000, 16'd32,    8'd64},
    {16'd100,  16'd2,     8'd20},
    {16'd7,    16'd3,     8'd64},
    {16'hFFF0, 16'd8,     8'd10},
    {16'd5,    16'd4,     8'd17},
    {16'h1234, 16'hFFFF,  8'd33},
    {16'd50,   16'd1,     8'd100},
    {16'd9,    16'd0,     8'd3}
  };

  logic        clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [15:0] base_i = '0, stride_i = '0;
  logic [6:0]  vl_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic        busy_o, done_o;
  logic [31:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] shadow [MVL];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlu_strided_load dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .vl_i(vl_i), .rd_idx_i(rd_idx_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] word_at(logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic int clamp_vl(int v);
    return (v > MVL) ? MVL : v;
  endfunction

  // edges from start edge to done, from per-bank free times
  function automatic int exp_cycles(logic [15:0] b, logic [15:0] s, int v);
    int free_t [8];
    int t = 0;
    logic [15:0] a;
    if (v == 0) return 0;
    for (int k = 0; k < 8; k++) free_t[k] = 0;
    for (int i = 0; i < v; i++) begin
      a = b + 16'(i) * s;
      t = t + 1;
      if (t < free_t[a[2:0]]) t = free_t[a[2:0]];
      free_t[a[2:0]] = t + 6;
    end
    return t + 12;
  endfunction

  task automatic check_eq(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic verify_reg(string tag, int v);
    for (int i = 0; i < MVL; i++) begin
      rd_idx_i = 6'(i);
      #1;
      check_eq((i < v) ? tag : "R8", $sformatf("elem %0d", i), rd_data_o, shadow[i]);
    end
  endtask

  task automatic run_load(input logic [15:0] b, input logic [15:0] s, input int v,
                          input int poke_at, output int cyc);
    @(negedge clk);
    base_i = b; stride_i = s; vl_i = 7'(v); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 2000) begin
      if (cyc == poke_at) begin
        base_i = 16'h7777; stride_i = 16'd3; vl_i = 7'd2; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (cyc == 1 && v > 0) check_eq("R10", "busy during load", busy_o, 1);
      @(posedge clk); #1;
      cyc++;
    end
    start_i = 1'b0;
    check_eq("R10", "busy at done", busy_o, 0);
    @(posedge clk); #1;
    check_eq("R4", "done one cycle", done_o, 0);
    for (int i = 0; i < clamp_vl(v); i++) shadow[i] = word_at(b + 16'(i) * s);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int cyc;
    for (int i = 0; i < MVL; i++) shadow[i] = '0;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1", "busy", busy_o, 0);
    check_eq("R1", "done", done_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    verify_reg("R1", MVL);

    // table of loads: timing and contents (R2 R3 R4 R5 R6 R8)
    for (int e = 0; e < NLOADS; e++) begin
      logic [15:0] b, s;
      int v;
      string tag;
      b = LOADS[e][39:24]; s = LOADS[e][23:8]; v = int'(LOADS[e][7:0]);
      tag = (e == 0) ? "R4" : (e == 1) ? "R5" : (e == 7) ? "R6" : "R3";
      run_load(b, s, v, -1, cyc);
      check_eq(tag, $sformatf("cycles load %0d", e), cyc, exp_cycles(b, s, clamp_vl(v)));
      if (e == 0) check_eq("R4", "unit stride 64", cyc, 76);
      if (e == 1) check_eq("R5", "same bank 64", cyc, 391);
      verify_reg("R2", clamp_vl(v));
    end

    // R7 zero length
    run_load(16'h4000, 16'd1, 0, -1, cyc);
    check_eq("R7", "zero length done", cyc, 0);
    verify_reg("R7", 0);

    // R9 start during load is ignored
    run_load(16'h0200, 16'd1, 64, 5, cyc);
    check_eq("R9", "cycles with poke", cyc, 76);
    check_eq("R9", "no restart", busy_o, 0);
    verify_reg("R9", MVL);

    finish_run();
  end
endmodule